// File: doc/BRIEF.md
# CAN Register Indirect Access Bridge

This block lets an 8-bit CPU reach a 256-location CAN controller register space through a handful of special-function-register (SFR) addresses. One SFR holds an address pointer, and a data-port SFR reads or writes the internal register that the pointer selects. Three more SFRs are fixed aliases onto the most-used control registers, so the CPU can reach them without moving the pointer.

A data-port access leaves the pointer in place while it is below a threshold (32 by default). Software can therefore poll low control and status registers repeatedly. At or above the threshold, the pointer steps forward after each data-port access, so a message in the transmit buffer (112 onward) or the receive FIFO RAM (128 onward) streams through the data port. Two of the aliases map reads and writes to different internal registers.

Every path is combinational from the SFR strobe to the internal register bus, and internal read data is returned to the CPU in the same cycle. Only the pointer is state.

Top module: `can_sfr_bridge`

## Requirements
- R1: After reset (rst_ni low), the pointer is 00h, and reading the pointer SFR (address DBh) returns 00h.
- R2: A write to the pointer SFR (DBh) loads the pointer. A read of DBh returns the pointer and causes no internal strobe.
- R3: A read or write of the data-port SFR (DAh) drives reg_addr_o with the pointer and pulses reg_rd_o or reg_wr_o. Read data from reg_rdata_i appears on sfr_rdata_o in the same cycle as the read strobe.
- R4: When the pointer is below 32, it keeps its value after a data-port read or write.
- R5: When the pointer is 32 or more, it increases by one after each data-port read or write.
- R6: An increment from FFh wraps the pointer to 00h.
- R7: The mode alias SFR (F1h) reads and writes internal address 0.
- R8: Reading the status alias SFR (D8h) returns internal address 2. Writing it targets internal address 4.
- R9: Reading the interrupt/command alias SFR (D9h) returns internal address 3. Writing it targets internal address 1.
- R10: Accesses to the three alias SFRs never change the pointer.
- R11: A pointer loaded at 112 streams consecutive bytes through the data port across the 127/128 boundary, reaching the transmit buffer and the FIFO RAM.
- R12: An access to an SFR address outside the five above produces no internal strobe, and its read data is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sfr_addr_i | input | 8 | SFR address from the CPU |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rd_i | input | 1 | SFR read strobe |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_rdata_o | output | 8 | SFR read data, same cycle as sfr_rd_i |
| reg_addr_o | output | 8 | Internal register address |
| reg_wdata_o | output | 8 | Internal register write data |
| reg_rd_o | output | 1 | Internal read strobe |
| reg_wr_o | output | 1 | Internal write strobe |
| reg_rdata_i | input | 8 | Internal register read data |

## Verification
The bench probes the auto-increment threshold from both sides, at 31 and at 32. A design that compares with the wrong bound would either advance while software polls a control register, or stall during a message transfer. It drives the pointer through FFh and across the 127/128 boundary, which exposes a missing wrap or a truncated counter. It also loads distinct values at internal addresses 1 through 4 and then reads and writes both asymmetric aliases, so a swapped read and write mapping returns or corrupts the wrong byte. Alias and unmapped accesses are bracketed by pointer read-backs, to catch a pointer that moves on a strobe it should ignore.

// File: rtl/can_br_pkg.sv
package can_br_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PTR,
    SEL_DATA,
    SEL_MODE,
    SEL_STAT,
    SEL_CMD
  } sfr_sel_e;

  // internal register indices the aliases depend on
  localparam logic [7:0] IDX_MODE    = 8'd0;
  localparam logic [7:0] IDX_COMMAND = 8'd1;
  localparam logic [7:0] IDX_STATUS  = 8'd2;
  localparam logic [7:0] IDX_IRQ     = 8'd3;
  localparam logic [7:0] IDX_IRQ_EN  = 8'd4;
endpackage

// File: rtl/can_br_decode.sv
module can_br_decode
  import can_br_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [7:0]  SFR_PTR   = 8'hDB,
  parameter logic [7:0]  SFR_DATA  = 8'hDA,
  parameter logic [7:0]  SFR_MODE  = 8'hF1,
  parameter logic [7:0]  SFR_STAT  = 8'hD8,
  parameter logic [7:0]  SFR_CMD   = 8'hD9
) (
  input  logic [7:0] sfr_addr_i,
  output sfr_sel_e   sel_o
);
  always_comb begin
    if      (sfr_addr_i == SFR_PTR)  sel_o = SEL_PTR;
    else if (sfr_addr_i == SFR_DATA) sel_o = SEL_DATA;
    else if (sfr_addr_i == SFR_MODE) sel_o = SEL_MODE;
    else if (sfr_addr_i == SFR_STAT) sel_o = SEL_STAT;
    else if (sfr_addr_i == SFR_CMD)  sel_o = SEL_CMD;
    else                             sel_o = SEL_NONE;
  end
endmodule

// File: rtl/can_br_ptr.sv
module can_br_ptr
  import can_br_pkg::*;
#(
  parameter int AW       = 8,
  parameter int INC_BASE = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sfr_sel_e      sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] INC_BASE_V = AW'(INC_BASE);

  logic [AW-1:0] ptr_q;
  logic          load, step;

  assign load = (sel_i == SEL_PTR) && wr_i;
  // low registers are polled in place; upper space streams
  assign step = (sel_i == SEL_DATA) && (rd_i || wr_i) && (ptr_q >= INC_BASE_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (load) ptr_q <= wdata_i;
    else if (step) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/can_br_route.sv
module can_br_route
  import can_br_pkg::*;
#(
  parameter int AW = 8
) (
  input  sfr_sel_e      sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_rd_o,
  output logic          reg_wr_o
);
  logic internal;

  always_comb begin
    internal   = 1'b1;
    reg_addr_o = '0;
    unique case (sel_i)
      SEL_DATA: reg_addr_o = ptr_i;
      SEL_MODE: reg_addr_o = AW'(IDX_MODE);
      SEL_STAT: reg_addr_o = wr_i ? AW'(IDX_IRQ_EN)  : AW'(IDX_STATUS);
      SEL_CMD:  reg_addr_o = wr_i ? AW'(IDX_COMMAND) : AW'(IDX_IRQ);
      default:  internal   = 1'b0;
    endcase
  end

  // write wins if both strobes are seen together
  assign reg_wr_o = internal && wr_i;
  assign reg_rd_o = internal && rd_i && !wr_i;
endmodule

// File: rtl/can_sfr_bridge.sv
module can_sfr_bridge
  import can_br_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         INC_BASE = 32,
  parameter logic [7:0] SFR_PTR  = 8'hDB,
  parameter logic [7:0] SFR_DATA = 8'hDA,
  parameter logic [7:0] SFR_MODE = 8'hF1,
  parameter logic [7:0] SFR_STAT = 8'hD8,
  parameter logic [7:0] SFR_CMD  = 8'hD9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    sfr_addr_i,
  input  logic [7:0]    sfr_wdata_i,
  input  logic          sfr_rd_i,
  input  logic          sfr_wr_i,
  output logic [7:0]    sfr_rdata_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_rd_o,
  output logic          reg_wr_o,
  input  logic [7:0]    reg_rdata_i
);
  sfr_sel_e      sel;
  logic [AW-1:0] ptr_q;

  can_br_decode #(
    .AW(AW), .SFR_PTR(SFR_PTR), .SFR_DATA(SFR_DATA),
    .SFR_MODE(SFR_MODE), .SFR_STAT(SFR_STAT), .SFR_CMD(SFR_CMD)
  ) u_decode (
    .sfr_addr_i (sfr_addr_i),
    .sel_o      (sel)
  );

  can_br_ptr #(.AW(AW), .INC_BASE(INC_BASE)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel),
    .rd_i    (sfr_rd_i),
    .wr_i    (sfr_wr_i),
    .wdata_i (AW'(sfr_wdata_i)),
    .ptr_o   (ptr_q)
  );

  can_br_route #(.AW(AW)) u_route (
    .sel_i      (sel),
    .rd_i       (sfr_rd_i),
    .wr_i       (sfr_wr_i),
    .ptr_i      (ptr_q),
    .reg_addr_o (reg_addr_o),
    .reg_rd_o   (reg_rd_o),
    .reg_wr_o   (reg_wr_o)
  );

  assign reg_wdata_o = sfr_wdata_i;

  always_comb begin
    if (!sfr_rd_i)           sfr_rdata_o = 8'h00;
    else if (sel == SEL_PTR) sfr_rdata_o = 8'(ptr_q);
    else if (reg_rd_o)       sfr_rdata_o = reg_rdata_i;
    else                     sfr_rdata_o = 8'h00;
  end
endmodule

// File: rtl/can_sfr_bridge_chk.sv
module can_sfr_bridge_chk #(
  parameter int         AW       = 8,
  parameter int         INC_BASE = 32,
  parameter logic [7:0] SFR_PTR  = 8'hDB,
  parameter logic [7:0] SFR_DATA = 8'hDA,
  parameter logic [7:0] SFR_MODE = 8'hF1,
  parameter logic [7:0] SFR_STAT = 8'hD8,
  parameter logic [7:0] SFR_CMD  = 8'hD9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    sfr_addr_i,
  input logic          sfr_rd_i,
  input logic          sfr_wr_i,
  input logic [AW-1:0] reg_addr_o,
  input logic          reg_rd_o,
  input logic          reg_wr_o,
  input logic [AW-1:0] ptr_q
);
  logic data_acc, alias_acc;
  assign data_acc  = (sfr_addr_i == SFR_DATA) && (sfr_rd_i || sfr_wr_i);
  assign alias_acc = ((sfr_addr_i == SFR_MODE) || (sfr_addr_i == SFR_STAT) ||
                      (sfr_addr_i == SFR_CMD)) && (sfr_rd_i || sfr_wr_i);

  AST_DATA_TARGETS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc |-> (reg_addr_o == ptr_q) && (reg_rd_o || reg_wr_o)); // R3
  AST_PTR_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && ptr_q < AW'(INC_BASE)) |=> $stable(ptr_q)); // R4
  AST_PTR_STEP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && ptr_q >= AW'(INC_BASE)) |=> ptr_q == AW'($past(ptr_q) + 1'b1)); // R5
  AST_STAT_WR_IRQ_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_wr_i && sfr_addr_i == SFR_STAT) |-> reg_wr_o && reg_addr_o == AW'(4)); // R8
  AST_CMD_RD_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_rd_i && !sfr_wr_i && sfr_addr_i == SFR_CMD) |-> reg_rd_o && reg_addr_o == AW'(3)); // R9
  AST_ALIAS_PTR_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_acc |=> $stable(ptr_q)); // R10
  AST_SINGLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o)); // R3
  AST_PTR_SFR_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == SFR_PTR) |-> !reg_rd_o && !reg_wr_o); // R2
endmodule

bind can_sfr_bridge can_sfr_bridge_chk #(
  .AW(AW), .INC_BASE(INC_BASE), .SFR_PTR(SFR_PTR), .SFR_DATA(SFR_DATA),
  .SFR_MODE(SFR_MODE), .SFR_STAT(SFR_STAT), .SFR_CMD(SFR_CMD)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sfr_addr_i (sfr_addr_i),
  .sfr_rd_i   (sfr_rd_i),
  .sfr_wr_i   (sfr_wr_i),
  .reg_addr_o (reg_addr_o),
  .reg_rd_o   (reg_rd_o),
  .reg_wr_o   (reg_wr_o),
  .ptr_q      (ptr_q)
);

// File: tb/can_sfr_bridge_bench.sv
`timescale 1ns/1ps
module can_sfr_bridge_bench;
  localparam logic [7:0] A_PTR  = 8'hDB;
  localparam logic [7:0] A_DATA = 8'hDA;
  localparam logic [7:0] A_MODE = 8'hF1;
  localparam logic [7:0] A_STAT = 8'hD8;
  localparam logic [7:0] A_CMD  = 8'hD9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic       sfr_rd = 1'b0, sfr_wr = 1'b0;
  logic [7:0] sfr_rdata, reg_addr, reg_wdata, reg_rdata;
  logic       reg_rd, reg_wr;
  logic [7:0] mem [256];

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  can_sfr_bridge u_can_sfr_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
    .sfr_rd_i(sfr_rd), .sfr_wr_i(sfr_wr), .sfr_rdata_o(sfr_rdata),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_rd_o(reg_rd), .reg_wr_o(reg_wr), .reg_rdata_i(reg_rdata)
  );

  // register space model
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_rd = 1'b1;
    #1 d = sfr_rdata;
    @(negedge clk);
    sfr_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    sfr_read(A_PTR, v);
    chk("R1 pointer after reset", v, 8'h00);
  endtask

  task automatic t_ptr_rw;
    logic [7:0] v;
    sfr_write(A_PTR, 8'h07);
    sfr_read(A_PTR, v);
    chk("R2 pointer readback", v, 8'h07);
  endtask

  task automatic t_low_poll;
    logic [7:0] v;
    sfr_write(A_PTR, 8'h1F);
    sfr_read(A_DATA, v);
    chk("R3 data read at 1F", v, 8'h1F ^ 8'h5A);
    sfr_read(A_DATA, v);
    chk("R4 repeat poll at 1F", v, 8'h1F ^ 8'h5A);
    sfr_write(A_DATA, 8'h33);
    sfr_read(A_PTR, v);
    chk("R4 pointer held at 1F", v, 8'h1F);
    chk("R3 write landed at 1F", mem[8'h1F], 8'h33);
  endtask

  task automatic t_inc;
    logic [7:0] v;
    sfr_write(A_PTR, 8'h20);
    sfr_read(A_DATA, v);
    chk("R5 read at threshold", v, 8'h20 ^ 8'h5A);
    sfr_read(A_PTR, v);
    chk("R5 pointer after read at 20", v, 8'h21);
    sfr_write(A_PTR, 8'h40);
    sfr_write(A_DATA, 8'hA1);
    sfr_write(A_DATA, 8'hA2);
    sfr_write(A_DATA, 8'hA3);
    chk("R5 burst byte 40", mem[8'h40], 8'hA1);
    chk("R5 burst byte 42", mem[8'h42], 8'hA3);
    sfr_read(A_PTR, v);
    chk("R5 pointer after burst", v, 8'h43);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    sfr_write(A_PTR, 8'hFE);
    sfr_read(A_DATA, v);
    sfr_read(A_DATA, v);
    chk("R6 read at FF", v, 8'hFF ^ 8'h5A);
    sfr_read(A_PTR, v);
    chk("R6 wrap to 00", v, 8'h00);
  endtask

  task automatic t_mode;
    logic [7:0] v;
    sfr_write(A_MODE, 8'h11);
    chk("R7 mode write to 0", mem[0], 8'h11);
    sfr_write(A_PTR, 8'h00);
    sfr_write(A_DATA, 8'h6C);
    sfr_read(A_MODE, v);
    chk("R7 mode read from 0", v, 8'h6C);
  endtask

  task automatic t_stat_cmd;
    logic [7:0] v;
    for (int i = 1; i <= 4; i++) begin
      sfr_write(A_PTR, 8'(i));
      sfr_write(A_DATA, 8'(8'h10 * i));
    end
    sfr_read(A_STAT, v);
    chk("R8 status read from 2", v, 8'h20);
    sfr_write(A_STAT, 8'h99);
    chk("R8 status write to 4", mem[4], 8'h99);
    chk("R8 status write spares 2", mem[2], 8'h20);
    sfr_read(A_CMD, v);
    chk("R9 irq read from 3", v, 8'h30);
    sfr_write(A_CMD, 8'h77);
    chk("R9 cmd write to 1", mem[1], 8'h77);
    chk("R9 cmd write spares 3", mem[3], 8'h30);
  endtask

  task automatic t_alias_ptr;
    logic [7:0] v;
    sfr_write(A_PTR, 8'h50);
    sfr_read(A_MODE, v);
    sfr_write(A_MODE, 8'h01);
    sfr_read(A_STAT, v);
    sfr_write(A_STAT, 8'h02);
    sfr_read(A_CMD, v);
    sfr_write(A_CMD, 8'h03);
    sfr_read(A_PTR, v);
    chk("R10 pointer unchanged by aliases", v, 8'h50);
  endtask

  task automatic t_txfifo;
    logic [7:0] v;
    sfr_write(A_PTR, 8'd112);
    for (int k = 0; k < 20; k++) sfr_write(A_DATA, 8'(8'hC0 + k));
    chk("R11 tx buffer first byte", mem[112], 8'hC0);
    chk("R11 byte at 127", mem[127], 8'hCF);
    chk("R11 fifo byte at 128", mem[128], 8'hD0);
    sfr_read(A_PTR, v);
    chk("R11 pointer after stream", v, 8'd132);
    sfr_write(A_PTR, 8'd127);
    sfr_read(A_DATA, v);
    chk("R11 read 127", v, 8'hCF);
    sfr_read(A_DATA, v);
    chk("R11 read 128", v, 8'hD0);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    logic       strobe;
    sfr_write(A_PTR, 8'h60);
    @(negedge clk);
    sfr_addr = 8'h80; sfr_rd = 1'b1;
    #1 v = sfr_rdata; strobe = reg_rd | reg_wr;
    @(negedge clk);
    sfr_rd = 1'b0;
    chk("R12 unmapped read data", v, 8'h00);
    chk("R12 unmapped read strobe", {7'd0, strobe}, 8'h00);
    @(negedge clk);
    sfr_addr = 8'h80; sfr_wdata = 8'hEE; sfr_wr = 1'b1;
    #1 strobe = reg_rd | reg_wr;
    @(negedge clk);
    sfr_wr = 1'b0;
    chk("R12 unmapped write strobe", {7'd0, strobe}, 8'h00);
    sfr_read(A_PTR, v);
    chk("R12 pointer untouched", v, 8'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr_rw();
    t_low_poll();
    t_inc();
    t_wrap();
    t_mode();
    t_stat_cmd();
    t_alias_ptr();
    t_txfifo();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule